// File: doc/BRIEF.md
# Free-running tick counter with coherent half-word reads

This peripheral keeps a 32-bit up-counter that advances once per rising edge of a slow tick input (nominally 32768 per second). The tick arrives from another clock domain; it passes through a two-flop synchronizer and an edge detector before it reaches the counter. The counter starts from zero at reset, runs freely and wraps silently.

A simple read-only bus slave exposes two registers: a constant revision word at byte offset 0x00 and the live count at byte offset 0x10. Full-word reads return the whole value. Software on a 16-bit path reads the low half-word first. That read also freezes the matching upper half in a holding register, and the following read at offset +2 returns the frozen copy, so the two halves always belong to the same count. Any write, any illegal access width and any unmapped or misaligned offset raises a one-cycle error flag.

Top module: `sync_tick_counter`

## Requirements
- R1: After reset the counter is zero, and `rd_valid` and `bus_err` are low until the first bus strobe.
- R2: The counter rises by exactly one for each rising edge of `tick_async`; a tick held high for many bus cycles counts once.
- R3: The counter wraps from its all-ones value to zero with no flag or other side effect.
- R4: A word read (`bus_size` = 2) at byte offset 0x00 returns 0x00000021.
- R5: A word read at byte offset 0x10 returns the counter value sampled in the strobe cycle. `rd_data` and `rd_valid` appear one cycle after the strobe, `rd_valid` and `bus_err` are high for that one cycle only, and `bus_err` stays low for a legal read.
- R6: A half-word read (`bus_size` = 1) with address bit 1 clear returns bits 15:0 of the selected register in `rd_data[15:0]`, upper bits zero, and copies bits 31:16 of that register into the holding register.
- R7: A half-word read with address bit 1 set returns the holding register in `rd_data[15:0]`, not the live upper counter bits, and raises no error.
- R8: A read with `bus_size` 0 (byte) or 3 (reserved), a misaligned word read (address bits 1:0 not zero) or a half-word read with address bit 0 set returns zero with `bus_err` high.
- R9: A write (`bus_wr` high with `bus_sel`) raises `bus_err`, gives no `rd_valid`, and leaves the counter and the holding register unchanged.
- R10: A read at any unmapped offset returns zero with `bus_err` high; a low half-word read there loads zero into the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_async | input | 1 | Slow tick from another clock domain |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address within the block |
| rd_data | output | 32 | Registered read data, held until the next access |
| rd_valid | output | 1 | One-cycle pulse marking a read result |
| bus_err | output | 1 | One-cycle pulse marking an illegal access |

## Verification
The key corner is the frozen upper half. The bench takes a low half-word read while the upper bits are zero, then runs more than 65536 ticks so the live upper half becomes one. A design that reads the live bits at offset +2 returns 1 where 0 is expected. A write placed between a low and a high read shows whether writes disturb the holding register. A low read at an unmapped offset must clear it, and a design that skips the capture there still returns the stale half. A tick held high for many cycles shows level counting rather than edge counting. A narrow counter instance shows whether the wrap is handled. Byte, reserved and misaligned reads must return zero with the error pulse, and a decoder that falls through to the count register fails that check.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [31:0] REV_WORD = 32'h0000_0021;
  localparam int unsigned REV_IDX  = 0;   // byte 0x00
  localparam int unsigned CNT_IDX  = 4;   // byte 0x10

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic logic [15:0] low_part(input logic [31:0] w);
    return w[15:0];
  endfunction

  function automatic logic [15:0] high_part(input logic [31:0] w);
    return w[31:16];
  endfunction

  function automatic logic [31:0] widen16(input logic [15:0] h);
    return {16'h0000, h};
  endfunction
endpackage

// File: rtl/stc_tick_sync.sv
module stc_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tick_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign tick_pulse = sync_q & ~prev_q;

  // R2: an edge yields a single-cycle enable
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + ONE;
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (&count)) |=> (count == '0));
endmodule

// File: rtl/stc_bus_regs.sv
module stc_bus_regs
  import stc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       count_word,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              err
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             reg_hit;
  logic [31:0]      reg_val;
  logic [31:0]      nxt_data;
  logic             nxt_err;
  logic             cap_en;
  logic [15:0]      cap_val;
  logic [15:0]      hold_q;
  acc_size_e        sz;

  assign word_idx = addr[ADDR_W-1:2];
  assign sz       = acc_size_e'(size);

  always_comb begin
    reg_hit = 1'b1;
    reg_val = '0;
    if (word_idx == IDX_W'(REV_IDX))      reg_val = REV_WORD;
    else if (word_idx == IDX_W'(CNT_IDX)) reg_val = count_word;
    else                                  reg_hit = 1'b0;
  end

  always_comb begin
    nxt_data = '0;
    nxt_err  = 1'b0;
    cap_en   = 1'b0;
    cap_val  = '0;
    if (sel && wr) begin
      nxt_err = 1'b1;
    end else if (sel) begin
      unique case (sz)
        SZ_WORD: begin
          if (reg_hit && addr[1:0] == 2'b00) nxt_data = reg_val;
          else                               nxt_err  = 1'b1;
        end
        SZ_HALF: begin
          if (addr[0]) begin
            nxt_err = 1'b1;
          end else if (addr[1]) begin
            nxt_data = widen16(hold_q);
          end else begin
            cap_en   = 1'b1;
            cap_val  = high_part(reg_val);
            nxt_data = widen16(low_part(reg_val));
            nxt_err  = !reg_hit;
          end
        end
        default: nxt_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (cap_en) hold_q <= cap_val;
      if (sel)    rd_data <= nxt_data;
      rd_valid <= sel && !wr;
      err      <= nxt_err;
    end
  end

  a_r5_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!rd_valid && !err));
  a_r9_write_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr) |=> (err && !rd_valid && rd_data == '0));
  a_r9_hold_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr && sz == SZ_HALF && addr[1:0] == 2'b00) |=> $stable(hold_q));
  a_r8_error_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rd_data == '0));
endmodule

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_async,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              bus_err
);
  logic             tick_en;
  logic [CNT_W-1:0] count;
  logic [31:0]      count_word;

  stc_tick_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_async (tick_async),
    .tick_pulse (tick_en)
  );

  stc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tick_en),
    .count (count)
  );

  generate
    if (CNT_W < 32) begin : g_pad
      assign count_word = {{(32-CNT_W){1'b0}}, count};
    end else begin : g_full
      assign count_word = count[31:0];
    end
  endgenerate

  stc_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (bus_sel),
    .wr         (bus_wr),
    .size       (bus_size),
    .addr       (bus_addr),
    .count_word (count_word),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .err        (bus_err)
  );
endmodule

// File: tb/sync_tick_counter_bench.sv
module sync_tick_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              tick_s = 1'b0;
  logic              sel = 1'b0;
  logic              wr = 1'b0;
  logic [1:0]        size = 2'd2;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       rdata, rdata_s;
  logic              rvalid, rvalid_s, berr, berr_s;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [31:0] exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tick_counter #(.ADDR_W(ADDR_W), .CNT_W(32)) u_sync_tick_counter (
    .clk(clk), .rst_n(rst_n), .tick_async(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_size(size), .bus_addr(addr), .rd_data(rdata), .rd_valid(rvalid),
    .bus_err(berr));

  sync_tick_counter #(.ADDR_W(ADDR_W), .CNT_W(4)) u_sync_tick_counter_small (
    .clk(clk), .rst_n(rst_n), .tick_async(tick_s), .bus_sel(sel), .bus_wr(wr),
    .bus_size(size), .bus_addr(addr), .rd_data(rdata_s), .rd_valid(rvalid_s),
    .bus_err(berr_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One access; outputs are sampled at the negedge after the registering edge.
  task automatic access(input logic w, input logic [1:0] sz, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    sel = 1'b1; wr = w; size = sz; addr = a;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic fast_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (4) @(negedge clk);
    exp_cnt += 32'(n);
  endtask

  task automatic t_reset();
    check("R1 rd_valid after reset", {31'd0, rvalid}, 32'd0);
    check("R1 bus_err after reset", {31'd0, berr}, 32'd0);
    access(1'b0, 2'd2, 8'h10);
    check("R1 count zero", rdata, 32'd0);
  endtask

  task automatic t_revision();
    access(1'b0, 2'd2, 8'h00);
    check("R4 revision", rdata, 32'h21);
    check("R5 rd_valid pulse", {31'd0, rvalid}, 32'd1);
    check("R5 no error", {31'd0, berr}, 32'd0);
    @(negedge clk);
    check("R5 rd_valid one cycle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_counting();
    @(negedge clk); tick = 1'b1;
    repeat (12) @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
    exp_cnt += 1;
    access(1'b0, 2'd2, 8'h10);
    check("R2 held tick counts once", rdata, exp_cnt);
    fast_ticks(5);
    access(1'b0, 2'd2, 8'h10);
    check("R2 five edges", rdata, exp_cnt);
    check("R5 count read no error", {31'd0, berr}, 32'd0);
  endtask

  task automatic t_half_latch();
    access(1'b0, 2'd1, 8'h10);
    check("R6 low half", rdata, {16'd0, exp_cnt[15:0]});
    fast_ticks(65536);
    access(1'b0, 2'd1, 8'h12);
    check("R7 frozen high half", rdata, 32'd0);
    check("R7 no error", {31'd0, berr}, 32'd0);
    access(1'b0, 2'd2, 8'h10);
    check("R5 live word", rdata, exp_cnt);
    access(1'b0, 2'd1, 8'h10);
    check("R6 low half again", rdata, {16'd0, exp_cnt[15:0]});
    access(1'b0, 2'd1, 8'h12);
    check("R6 captured high half", rdata, {16'd0, exp_cnt[31:16]});
  endtask

  task automatic t_bad_width();
    access(1'b0, 2'd0, 8'h10);
    check("R8 byte data", rdata, 32'd0);
    check("R8 byte err", {31'd0, berr}, 32'd1);
    access(1'b0, 2'd3, 8'h10);
    check("R8 reserved err", {31'd0, berr}, 32'd1);
    access(1'b0, 2'd2, 8'h12);
    check("R8 misaligned word data", rdata, 32'd0);
    check("R8 misaligned word err", {31'd0, berr}, 32'd1);
    access(1'b0, 2'd1, 8'h11);
    check("R8 odd half err", {31'd0, berr}, 32'd1);
  endtask

  task automatic t_write();
    access(1'b1, 2'd2, 8'h10);
    check("R9 write err", {31'd0, berr}, 32'd1);
    check("R9 write no rd_valid", {31'd0, rvalid}, 32'd0);
    access(1'b1, 2'd1, 8'h12);
    access(1'b0, 2'd1, 8'h12);
    check("R9 hold unchanged", rdata, {16'd0, exp_cnt[31:16]});
    access(1'b0, 2'd2, 8'h10);
    check("R9 count unchanged", rdata, exp_cnt);
  endtask

  task automatic t_unmapped();
    access(1'b0, 2'd2, 8'h08);
    check("R10 unmapped data", rdata, 32'd0);
    check("R10 unmapped err", {31'd0, berr}, 32'd1);
    access(1'b0, 2'd1, 8'h40);
    check("R10 unmapped half err", {31'd0, berr}, 32'd1);
    access(1'b0, 2'd1, 8'h42);
    check("R10 hold cleared", rdata, 32'd0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tick_s = 1'b1;
      @(negedge clk); tick_s = 1'b0;
    end
    repeat (4) @(negedge clk);
    access(1'b0, 2'd2, 8'h10);
    check("R3 wrapped to zero", rdata_s, 32'd0);
    check("R3 no flag on wrap", {31'd0, berr_s}, 32'd0);
    @(negedge clk); tick_s = 1'b1;
    @(negedge clk); tick_s = 1'b0;
    repeat (4) @(negedge clk);
    access(1'b0, 2'd2, 8'h10);
    check("R3 counts after wrap", rdata_s, 32'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_revision();
    t_counting();
    t_half_latch();
    t_bad_width();
    t_write();
    t_unmapped();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule